// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer with Row Refresh

This block turns machine-cycle requests from a small 8-bit processor core into external memory bus timing. The core presents a cycle kind (opcode fetch, memory read or memory write), an address and, for writes, a data byte, then raises a request. The sequencer steps through one clock per bus state. It drives active-low strobes for memory request, read, write, fetch-cycle marker and refresh. It returns a one-clock done pulse in the last state, and it captures read data into a register the core can read.

An opcode fetch is one state longer than a data access. Its first two states carry the access itself. Its last two states put a dynamic-memory row address on the address bus and assert the refresh strobe. The low bits of that address come from an internal row counter that advances once per fetch. The high bits come from an input byte. Memory can therefore be refreshed with no external circuit. Address and data travel on separate buses, and the data bus never carries status. A wait input stretches any access while memory is not ready.

Top module: `bus_cycle_gen`

## Requirements
- R1: While reset is low and in the state after it, every strobe is high, done_o is low, data_oe_o is low and rdata_o is zero.
- R2: A fetch (kind 0) with no waits lasts exactly 4 states. m1_no, mreq_no and rd_no are low in states 1 and 2, and done_o is high only in state 4.
- R3: In a fetch, data_i is captured at the end of the last access state (state 2 or the last wait state). It is shown on rdata_o from the next state on.
- R4: In fetch states 3 and 4, rfsh_no is low and m1_no and rd_no are high. mreq_no is low in state 3 only. addr_o carries rfsh_hi_i in bits 15:8, zero in bit 7 and the row counter in bits 6:0.
- R5: The row counter is 0 after reset and advances by one after each fetch. It wraps from 127 to 0.
- R6: A read (kind 1) lasts 3 states. mreq_no and rd_no are low in states 1 and 2, and data is captured at the end of state 2. done_o is high in state 3. addr_o holds the request address in every state.
- R7: A write (kind 2) lasts 3 states. data_o equals the write byte and data_oe_o is high from state 1 through state 3. mreq_no is low in states 1 and 2, and wr_no is low in state 2 only, so data is stable a state before and after the write strobe.
- R8: wait_ni low at the end of state 2, or of a wait state, adds one wait state with the same strobes as state 2. The cycle length grows by exactly the number of added states.
- R9: Kind 3 runs as a read. After the state with done_o, the bus is idle for at least one state with all strobes high.
- R10: rd_no and wr_no are never low together, and data_oe_o stays low during fetch and read cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus state per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Cycle request, taken while idle |
| kind_i | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write byte |
| rfsh_hi_i | input | 8 | High address byte during refresh |
| wait_ni | input | 1 | Low stretches the access |
| data_i | input | 8 | Data bus input |
| done_o | output | 1 | High in the last state of a cycle |
| rdata_o | output | 8 | Last captured read or opcode byte |
| addr_o | output | 16 | Address bus |
| data_o | output | 8 | Data bus output |
| data_oe_o | output | 1 | Data bus output enable |
| mreq_no | output | 1 | Memory request, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| m1_no | output | 1 | Fetch cycle marker, active low |
| rfsh_no | output | 1 | Refresh strobe, active low |

## Verification
Each cycle kind runs with no waits and then with one to three wait states. Every state is compared with a per-state strobe pattern, which separates the 4-state fetch from the 3-state accesses and shows where the stretch is inserted. data_i carries the wanted byte only in the last access state, so a capture one state early or late reads its complement. A long run of fetches drives the row counter through 127 to 0 while the high refresh byte is changed. The reserved kind is run to confirm it decodes as a read.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4,
    S_T4   = 3'd5
  } st_e;
endpackage

// File: rtl/bcg_seq.sv
module bcg_seq
  import bcg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] kind_i,
  input  logic       wait_ni,
  output st_e        st_o,
  output logic       fetch_o,
  output logic       write_o,
  output logic       start_o,
  output logic       capture_o,
  output logic       done_o
);
  st_e  st_q, st_d;
  logic fetch_q, write_q;

  assign start_o = (st_q == S_IDLE) && req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:     if (req_i) st_d = S_T1;
      S_T1:       st_d = S_T2;
      S_T2, S_TW: st_d = wait_ni ? S_T3 : S_TW;
      S_T3:       st_d = fetch_q ? S_T4 : S_IDLE;
      S_T4:       st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      fetch_q <= 1'b0;
      write_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        fetch_q <= (kind_i == K_FETCH);
        write_q <= (kind_i == K_WRITE);
      end
    end
  end

  assign st_o      = st_q;
  assign fetch_o   = fetch_q;
  assign write_o   = write_q;
  assign capture_o = ((st_q == S_T2) || (st_q == S_TW)) && wait_ni;
  assign done_o    = ((st_q == S_T3) && !fetch_q) || (st_q == S_T4);
endmodule

// File: rtl/bcg_refresh.sv
module bcg_refresh #(
  parameter int ROW_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;  // natural wrap
  end

  assign row_o = row_q;
endmodule

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen
  import bcg_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int HI_W  = 8,
  parameter int ROW_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [HI_W-1:0] rfsh_hi_i,
  input  logic            wait_ni,
  input  logic [DW-1:0]   data_i,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic            data_oe_o,
  output logic            mreq_no,
  output logic            rd_no,
  output logic            wr_no,
  output logic            m1_no,
  output logic            rfsh_no
);
  localparam int LOW_W = AW - HI_W;

  st_e              st;
  logic             fetch, write, start, capture;
  logic [ROW_W-1:0] row;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             access, strobe_ph, rfsh_ph;

  bcg_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .kind_i   (kind_i),
    .wait_ni  (wait_ni),
    .st_o     (st),
    .fetch_o  (fetch),
    .write_o  (write),
    .start_o  (start),
    .capture_o(capture),
    .done_o   (done_o)
  );

  bcg_refresh #(.ROW_W(ROW_W)) u_rfsh (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (st == S_T4),
    .row_o (row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture && !write) rdata_q <= data_i;
    end
  end

  assign access    = (st == S_T1) || (st == S_T2) || (st == S_TW);
  assign strobe_ph = (st == S_T2) || (st == S_TW);
  assign rfsh_ph   = fetch && ((st == S_T3) || (st == S_T4));

  assign mreq_no   = !(access || (fetch && st == S_T3));
  assign rd_no     = !(access && !write);
  assign wr_no     = !(strobe_ph && write);
  assign m1_no     = !(access && fetch);
  assign rfsh_no   = !rfsh_ph;
  assign data_oe_o = write && (st != S_IDLE);
  assign data_o    = wdata_q;
  assign rdata_o   = rdata_q;
  assign addr_o    = rfsh_ph ? {rfsh_hi_i, LOW_W'(row)} : addr_q;
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wait_ni,
  input logic done_o,
  input logic data_oe_o,
  input logic mreq_no,
  input logic rd_no,
  input logic wr_no,
  input logic m1_no,
  input logic rfsh_no
);
  // R2
  m1_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m1_no |-> (!mreq_no && !rd_no));
  // R4
  rfsh_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_no |-> (m1_no && rd_no && wr_no));
  // R10
  no_rd_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R7
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> data_oe_o);
  // R8
  wait_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && !wait_ni) |=> !wr_no);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && mreq_no && rfsh_no));
endmodule

bind bus_cycle_gen bcg_chk u_chk (.*);

// File: tb/bus_cycle_gen_test.sv
module bus_cycle_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rfsh_hi_i = 8'hA5;
  logic        wait_ni = 1'b1;
  logic [7:0]  data_i = '0;
  logic        done_o, data_oe_o, mreq_no, rd_no, wr_no, m1_no, rfsh_no;
  logic [7:0]  rdata_o, data_o;
  logic [15:0] addr_o;

  int vec = 0;
  int miss = 0;
  logic [6:0] exp_row = '0;
  logic [6:0] last_row = '0;

  bus_cycle_gen uut (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    #4000000;
    miss++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: act=%h exp=%h", tg, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rv, input int nw, input string tg);
    bit fetch = (k == 2'd0);
    bit write = (k == 2'd2);
    int len = (fetch ? 4 : 3) + nw;
    int last_acc = 2 + nw;
    int s = 0;
    bit done_seen = 0;
    logic [6:0] act, exp;
    logic [15:0] ea;
    kind_i = k; addr_i = a; wdata_i = wd; req_i = 1'b1; data_i = ~rv;
    @(posedge clk_i);
    while (!done_seen && s < 24) begin
      @(negedge clk_i);
      s++;
      if (s == 1) req_i = 1'b0;
      begin
        bit acc = (s <= last_acc);
        bit erf = fetch && (s > last_acc);
        exp = {fetch && acc, acc || (fetch && s == last_acc + 1), acc && !write,
               write && s >= 2 && s <= last_acc, erf, write, s == len};
        act = {~m1_no, ~mreq_no, ~rd_no, ~wr_no, ~rfsh_no, data_oe_o, done_o};
        chk(act == exp, tg, 32'(act), 32'(exp));
        ea = erf ? {rfsh_hi_i, 1'b0, exp_row} : a;
        chk(addr_o == ea, erf ? "R4" : tg, 32'(addr_o), 32'(ea));
        if (erf) last_row = addr_o[6:0];
        if (write) chk(data_o == wd, "R7", 32'(data_o), 32'(wd));
        if (s == last_acc + 1 && !write)
          chk(rdata_o == rv, fetch ? "R3" : "R6", 32'(rdata_o), 32'(rv));
        chk(!(!rd_no && !wr_no) && (write || !data_oe_o), "R10",
            32'({rd_no, wr_no, data_oe_o}), 32'(3'b110));
      end
      wait_ni = !(s >= 2 && s < last_acc);
      data_i = (s == last_acc) ? rv : ~rv;
      done_seen = done_o;
    end
    wait_ni = 1'b1;
    chk(s == len, (nw > 0) ? "R8" : tg, 32'(s), 32'(len));
    if (fetch) exp_row = exp_row + 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    act = {~m1_no, ~mreq_no, ~rd_no, ~wr_no, ~rfsh_no, data_oe_o, done_o};
    chk(act == 7'd0, "R9", 32'(act), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk({m1_no, mreq_no, rd_no, wr_no, rfsh_no} == 5'h1f && !done_o && !data_oe_o && rdata_o == 8'h00,
        "R1", 32'({m1_no, mreq_no, rd_no, wr_no, rfsh_no, done_o, data_oe_o, rdata_o}), 32'h1f00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({m1_no, mreq_no, rd_no, wr_no, rfsh_no} == 5'h1f && !done_o && rdata_o == 8'h00,
        "R1", 32'({m1_no, mreq_no, rd_no, wr_no, rfsh_no, done_o, rdata_o}), 32'h1f00);
  endtask

  task automatic t_fetch;
    run_cycle(2'd0, 16'h1234, 8'h00, 8'h3C, 0, "R2");
    rfsh_hi_i = 8'h5A;
    run_cycle(2'd0, 16'hFFFE, 8'h00, 8'hC3, 0, "R2");
  endtask

  task automatic t_read;
    run_cycle(2'd1, 16'h8001, 8'h00, 8'h96, 0, "R6");
    run_cycle(2'd1, 16'h0000, 8'h00, 8'h00, 0, "R6");
  endtask

  task automatic t_write;
    run_cycle(2'd2, 16'h4321, 8'hE7, 8'h11, 0, "R7");
    run_cycle(2'd2, 16'hAAAA, 8'h18, 8'h22, 0, "R7");
  endtask

  task automatic t_wait;
    run_cycle(2'd0, 16'h0100, 8'h00, 8'h7E, 1, "R8");
    run_cycle(2'd1, 16'h0200, 8'h00, 8'h81, 3, "R8");
    run_cycle(2'd2, 16'h0300, 8'h99, 8'h00, 2, "R8");
  endtask

  task automatic t_rsvd;
    run_cycle(2'd3, 16'hBEEF, 8'h00, 8'h6B, 0, "R9");
  endtask

  task automatic t_wrap;
    rfsh_hi_i = 8'hC0;
    while (exp_row != 7'd127) run_cycle(2'd0, 16'h0040, 8'h00, 8'h01, 0, "R2");
    run_cycle(2'd0, 16'h0041, 8'h00, 8'h02, 0, "R2");
    chk(last_row == 7'd127, "R5", 32'(last_row), 32'd127);
    run_cycle(2'd0, 16'h0042, 8'h00, 8'h03, 0, "R2");
    chk(last_row == 7'd0, "R5", 32'(last_row), 32'd0);
    run_cycle(2'd0, 16'h0043, 8'h00, 8'h04, 0, "R2");
    chk(last_row == 7'd1, "R5", 32'(last_row), 32'd1);
  endtask

  initial begin
    t_reset();
    t_fetch();
    t_read();
    t_write();
    t_wait();
    t_rsvd();
    t_wrap();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule